// File: doc/BRIEF.md
# Two-Wire Target Write Receiver

This block is the receive half of a two-wire bus controller when the controller acts as a target. Software stores a 7-bit own address in an address register. It then writes the control register with the target-enable bit set, which copies that stored address into the live match address. Later changes to the stored address have no effect until the enable bit is written again.

A bus layer below the block reports byte-level events: a write start carrying the 7-bit address that was seen, a received data byte, and a stop. When a write start carries the live match address, the block enters its data phase. It puts the address, shifted up by one, into the receive byte field and flags both an address match and a completed receive. Each later data byte replaces the byte in the field and flags another completed receive. A stop flags a normal end and takes the block back to idle. Software lets the bus move on by writing the receive-handling command bit during the data phase, which produces a one-cycle acknowledge pulse toward the bus.

The register port uses word selects: 0 control, 1 interrupt enable, 2 interrupt status, 3 command, 4 own address, 5 byte buffer. Status bits: bit 0 receive done, bit 1 normal stop, bit 2 address match.

Top module: `i2ct_rx_top`

## Requirements
- R1: After reset every register reads zero, the block is idle, and `irq` and `bus_ack` are low.
- R2: A write to control (select 0) stores only the bits in mask 0x0071C3FF, and a read returns the stored value.
- R3: Writing control with bit 1 set copies the own address into the match address and arms the target. Writing control with bit 1 clear disarms it. A write start is accepted only when the target is armed and the start address equals the match address. Any other write start changes neither the status nor the byte buffer.
- R4: An accepted write start loads byte buffer bits 15:8 with the address shifted left by one, sets status bits 2 and 0, and enters the data phase. All of this is visible the cycle after the event.
- R5: In the data phase a data byte replaces byte buffer bits 15:8 and sets status bit 0. In idle a data byte changes nothing.
- R6: In the data phase a stop sets status bit 1 and returns the block to idle.
- R7: `irq` is high exactly when some status bit is set whose enable bit (select 1, bits 2:0) is set. Status bit 2 drives `irq` even when its enable bit is clear.
- R8: Writing a one to a status bit clears it. A flag raised in the same cycle as the clear stays set.
- R9: A write to select 3 with bit 0 set during the data phase gives `bus_ack` high for exactly the following cycle. The same write in idle gives no pulse.
- R10: The own address register (select 4) keeps 7 bits, resets to zero, and reads back with bits 31:7 at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current select (combinational) |
| ev_start_wr | input | 1 | Bus saw a start with the write direction |
| ev_addr | input | 7 | Address that came with the start |
| ev_data | input | 1 | Bus delivered a data byte |
| ev_byte | input | 8 | The delivered data byte |
| ev_stop | input | 1 | Bus saw a stop |
| irq | output | 1 | Interrupt: OR of the status bits that pass the mask |
| bus_ack | output | 1 | One-cycle acknowledge toward the bus |

## Verification
A table of address and data pairs runs the full sequence for each pair: arm, matched start, data byte, acknowledge, stop, then a late byte and a late acknowledge. The pairs include an all-ones address with a 0xFF byte and a low address with a 0x00 byte, so a wrong shift or a truncated field shows up in the readback. Directed cases cover the conditions under which a start is refused: target disarmed, wrong address, and own address changed without re-arming. Further cases set and clear the enable bits to show that only the match flag bypasses the mask, and raise a flag in the same cycle as its clear to show that the raise wins.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    localparam int DATA_W   = 32;
    localparam int SEL_W    = 3;
    localparam int ADDR_W   = 7;
    localparam int BYTE_W   = ADDR_W + 1;
    localparam int NSTS     = 3;

    localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h0071C3FF;
    localparam int TGT_EN_BIT    = 1;
    localparam int CMD_RXH_BIT   = 0;
    localparam int BUF_LSB       = 8;

    localparam int ST_RX_DONE = 0;
    localparam int ST_STOP    = 1;
    localparam int ST_MATCH   = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL    = 3'd0,
        SEL_IRQ_EN  = 3'd1,
        SEL_IRQ_STS = 3'd2,
        SEL_CMD     = 3'd3,
        SEL_OWN     = 3'd4,
        SEL_BUF     = 3'd5
    } reg_sel_e;

    typedef enum logic {
        TS_IDLE = 1'b0,
        TS_DATA = 1'b1
    } tgt_state_e;
endpackage

// File: rtl/i2ct_regs.sv
module i2ct_regs
    import i2ct_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W,
    parameter int NS = NSTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [NS-1:0]     sts_q,
    input  logic [BW-1:0]     rx_byte_q,
    output logic [DW-1:0]     reg_rdata,
    output logic [NS-1:0]     irq_en_q,
    output logic [AW-1:0]     match_addr_q,
    output logic              armed_q,
    output logic              cmd_rxh,
    output logic              sts_wr,
    output logic [NS-1:0]     sts_wmask
);
    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [NS-1:0] irq_en;
        logic [AW-1:0] own;
        logic [AW-1:0] match;
        logic          armed;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            case (reg_sel_e'(reg_addr))
                SEL_CTRL: begin
                    r_d.ctrl = reg_wdata & CTRL_KEEP;
                    if (reg_wdata[TGT_EN_BIT]) begin
                        r_d.match = r_q.own;
                        r_d.armed = 1'b1;
                    end else begin
                        r_d.armed = 1'b0;
                    end
                end
                SEL_IRQ_EN: r_d.irq_en = reg_wdata[NS-1:0];
                SEL_OWN:    r_d.own    = reg_wdata[AW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq_en_q     = r_q.irq_en;
    assign match_addr_q = r_q.match;
    assign armed_q      = r_q.armed;
    assign cmd_rxh      = reg_we && (reg_addr == SEL_CMD) && reg_wdata[CMD_RXH_BIT];
    assign sts_wr       = reg_we && (reg_addr == SEL_IRQ_STS);
    assign sts_wmask    = reg_wdata[NS-1:0];

    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_addr))
            SEL_CTRL:    reg_rdata = r_q.ctrl;
            SEL_IRQ_EN:  reg_rdata = {{(DW-NS){1'b0}}, r_q.irq_en};
            SEL_IRQ_STS: reg_rdata = {{(DW-NS){1'b0}}, sts_q};
            SEL_OWN:     reg_rdata = {{(DW-AW){1'b0}}, r_q.own};
            SEL_BUF:     reg_rdata = {{(DW-BW-BUF_LSB){1'b0}}, rx_byte_q, {BUF_LSB{1'b0}}};
            default:     reg_rdata = '0;
        endcase
    end

    // R2: control keeps only the allowed bits of the written word
    p_ctrl_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == SEL_CTRL) |=> (r_q.ctrl == ($past(reg_wdata) & CTRL_KEEP)));

    // R3: enabling copies the own address into the match address
    p_arm_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == SEL_CTRL && reg_wdata[TGT_EN_BIT])
        |=> (armed_q && match_addr_q == $past(r_q.own)));
endmodule

// File: rtl/i2ct_rx_fsm.sv
module i2ct_rx_fsm
    import i2ct_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NS = NSTS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ev_start_wr,
    input  logic [AW-1:0]  ev_addr,
    input  logic           ev_data,
    input  logic [AW:0]    ev_byte,
    input  logic           ev_stop,
    input  logic           armed_q,
    input  logic [AW-1:0]  match_addr_q,
    input  logic           cmd_rxh,
    output logic [AW:0]    rx_byte_q,
    output logic [NS-1:0]  sts_set,
    output logic           bus_ack
);
    localparam int BW = AW + 1;

    typedef struct packed {
        tgt_state_e    state;
        logic [BW-1:0] rx_byte;
        logic          ack;
    } fsm_t;

    fsm_t f_d, f_q;
    logic start_hit;

    always_comb begin
        f_d       = f_q;
        f_d.ack   = 1'b0;
        sts_set   = '0;
        start_hit = ev_start_wr && armed_q && (ev_addr == match_addr_q);

        if (start_hit) begin
            f_d.rx_byte          = {ev_addr, 1'b0};
            f_d.state            = TS_DATA;
            sts_set[ST_MATCH]    = 1'b1;
            sts_set[ST_RX_DONE]  = 1'b1;
        end else if (f_q.state == TS_DATA) begin
            if (ev_data) begin
                f_d.rx_byte         = ev_byte;
                sts_set[ST_RX_DONE] = 1'b1;
            end
            if (ev_stop) begin
                f_d.state        = TS_IDLE;
                sts_set[ST_STOP] = 1'b1;
            end
        end

        if (f_q.state == TS_DATA && cmd_rxh) begin
            f_d.ack = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{state: TS_IDLE, rx_byte: '0, ack: 1'b0};
        else        f_q <= f_d;
    end

    assign rx_byte_q = f_q.rx_byte;
    assign bus_ack   = f_q.ack;

    // R9: acknowledge pulse only follows a cycle spent in the data phase
    p_ack_in_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(f_q.state == TS_DATA));

    // R9: acknowledge lasts a single cycle unless a new command arrives
    p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !cmd_rxh) |=> !bus_ack);

    // R4: an accepted start enters the data phase with the shifted address
    p_start_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start_wr && armed_q && ev_addr == match_addr_q)
        |=> (f_q.state == TS_DATA && rx_byte_q == {$past(ev_addr), 1'b0}));

    // R6: a stop in the data phase returns to idle
    p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !ev_start_wr && f_q.state == TS_DATA) |=> (f_q.state == TS_IDLE));

    // R5: idle ignores data bytes
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == TS_IDLE && !ev_start_wr) |=> $stable(rx_byte_q));
endmodule

// File: rtl/i2ct_irq.sv
module i2ct_irq
    import i2ct_pkg::*;
#(
    parameter int NS = NSTS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NS-1:0]  sts_set,
    input  logic           sts_wr,
    input  logic [NS-1:0]  sts_wmask,
    input  logic [NS-1:0]  irq_en_q,
    output logic [NS-1:0]  sts_q,
    output logic           irq
);
    localparam logic [NS-1:0] BYPASS = NS'(1) << ST_MATCH;

    typedef struct packed {
        logic [NS-1:0] sts;
    } irq_t;

    irq_t s_d, s_q;
    logic [NS-1:0] clr;

    always_comb begin
        s_d   = s_q;
        clr   = sts_wr ? sts_wmask : '0;
        s_d.sts = (s_q.sts & ~clr) | sts_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sts_q = s_q.sts;
    assign irq   = |(s_q.sts & (irq_en_q | BYPASS));

    // R7: the match flag always reaches the interrupt line
    p_match_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sts_q[ST_MATCH] |-> irq);

    // R8: written ones clear flags when nothing is raised
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && sts_set == '0) |=> ((sts_q & $past(sts_wmask)) == '0));

    // R8: raised flags survive a same-cycle clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_set != '0) |=> ((sts_q & $past(sts_set)) == $past(sts_set)));
endmodule

// File: rtl/i2ct_rx_top.sv
module i2ct_rx_top
    import i2ct_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [SEL_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                ev_start_wr,
    input  logic [ADDR_W-1:0]   ev_addr,
    input  logic                ev_data,
    input  logic [BYTE_W-1:0]   ev_byte,
    input  logic                ev_stop,
    output logic                irq,
    output logic                bus_ack
);
    logic [NSTS-1:0]   sts_q, sts_set, irq_en_q, sts_wmask;
    logic [BYTE_W-1:0] rx_byte_q;
    logic [ADDR_W-1:0] match_addr_q;
    logic              armed_q, cmd_rxh, sts_wr;

    i2ct_regs #(.DW(DATA_W), .AW(ADDR_W), .BW(BYTE_W), .NS(NSTS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .sts_q        (sts_q),
        .rx_byte_q    (rx_byte_q),
        .reg_rdata    (reg_rdata),
        .irq_en_q     (irq_en_q),
        .match_addr_q (match_addr_q),
        .armed_q      (armed_q),
        .cmd_rxh      (cmd_rxh),
        .sts_wr       (sts_wr),
        .sts_wmask    (sts_wmask)
    );

    i2ct_rx_fsm #(.AW(ADDR_W), .NS(NSTS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_start_wr  (ev_start_wr),
        .ev_addr      (ev_addr),
        .ev_data      (ev_data),
        .ev_byte      (ev_byte),
        .ev_stop      (ev_stop),
        .armed_q      (armed_q),
        .match_addr_q (match_addr_q),
        .cmd_rxh      (cmd_rxh),
        .rx_byte_q    (rx_byte_q),
        .sts_set      (sts_set),
        .bus_ack      (bus_ack)
    );

    i2ct_irq #(.NS(NSTS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sts_set   (sts_set),
        .sts_wr    (sts_wr),
        .sts_wmask (sts_wmask),
        .irq_en_q  (irq_en_q),
        .sts_q     (sts_q),
        .irq       (irq)
    );
endmodule

// File: tb/sim_i2ct_rx_top.sv
module sim_i2ct_rx_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_start_wr = 1'b0;
    logic [6:0]  ev_addr = '0;
    logic        ev_data = 1'b0;
    logic [7:0]  ev_byte = '0;
    logic        ev_stop = 1'b0;
    logic        irq, bus_ack;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2ct_rx_top u0 (.*);

    // table: {own address, data byte}
    localparam logic [14:0] VEC [4] = '{
        {7'h2A, 8'h5C}, {7'h7F, 8'hFF}, {7'h01, 8'h00}, {7'h55, 8'hA3}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ev_start(input logic [6:0] a);
        @(negedge clk);
        ev_start_wr = 1'b1; ev_addr = a;
        @(negedge clk);
        ev_start_wr = 1'b0;
    endtask

    task automatic ev_dat(input logic [7:0] b);
        @(negedge clk);
        ev_data = 1'b1; ev_byte = b;
        @(negedge clk);
        ev_data = 1'b0;
    endtask

    task automatic ev_stp();
        @(negedge clk);
        ev_stop = 1'b1;
        @(negedge clk);
        ev_stop = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd2, v); chk("R1 status", v, 0);
        rd(3'd5, v); chk("R1 buffer", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 ack", {31'b0, bus_ack}, 0);
        rd(3'd4, v); chk("R10 own reset", v, 0);

        // R2 control mask
        wr(3'd0, 32'hFFFF_FFFD);
        rd(3'd0, v); chk("R2 ctrl mask", v, 32'h0071_C3FD);
        wr(3'd0, 32'h0);

        // R10 own address width
        wr(3'd4, 32'hFFFF_FFAA);
        rd(3'd4, v); chk("R10 own readback", v, 32'h2A);

        // table walk: full transfer per entry
        for (int i = 0; i < 4; i++) begin
            logic [6:0] a;
            logic [7:0] b;
            a = VEC[i][14:8];
            b = VEC[i][7:0];
            wr(3'd1, 0);
            wr(3'd4, {25'b0, a});
            wr(3'd0, 32'h2);
            wr(3'd2, 32'h7);
            ev_start(a);
            rd(3'd5, v); chk("R4 buffer address", v, {16'b0, a, 1'b0, 8'b0});
            rd(3'd2, v); chk("R4 status", v, 32'h5);
            chk("R7 match bypass", {31'b0, irq}, 1);
            wr(3'd2, 32'h7);
            chk("R7 irq masked clear", {31'b0, irq}, 0);
            ev_dat(b);
            rd(3'd5, v); chk("R5 buffer byte", v, {16'b0, b, 8'b0});
            rd(3'd2, v); chk("R5 rx done", v, 32'h1);
            chk("R7 rx done masked", {31'b0, irq}, 0);
            wr(3'd3, 32'h1);
            chk("R9 ack pulse", {31'b0, bus_ack}, 1);
            @(negedge clk);
            chk("R9 ack ends", {31'b0, bus_ack}, 0);
            ev_stp();
            rd(3'd2, v); chk("R6 stop flag", v, 32'h3);
            ev_dat(~b);
            rd(3'd5, v); chk("R5 idle byte ignored", v, {16'b0, b, 8'b0});
            rd(3'd2, v); chk("R6 idle status held", v, 32'h3);
            wr(3'd3, 32'h1);
            chk("R9 no ack in idle", {31'b0, bus_ack}, 0);
        end

        // R3 disarmed target refuses start
        wr(3'd2, 32'h7);
        wr(3'd0, 32'h0);
        ev_start(7'h55);
        rd(3'd2, v); chk("R3 disarmed status", v, 0);
        rd(3'd5, v); chk("R3 disarmed buffer", v, {16'b0, 8'hA3, 8'b0});

        // R3 wrong address and stale own address
        wr(3'd4, 32'h10);
        wr(3'd0, 32'h2);
        ev_start(7'h11);
        rd(3'd2, v); chk("R3 mismatch status", v, 0);
        wr(3'd4, 32'h20);
        ev_start(7'h20);
        rd(3'd2, v); chk("R3 not rearmed", v, 0);
        ev_start(7'h10);
        rd(3'd2, v); chk("R3 armed match", v, 32'h5);
        rd(3'd5, v); chk("R4 buffer 0x10", v, 32'h2000);

        // R7 mask behaviour
        wr(3'd2, 32'h4);
        rd(3'd2, v); chk("R8 match cleared", v, 32'h1);
        chk("R7 masked off", {31'b0, irq}, 0);
        wr(3'd1, 32'h1);
        chk("R7 enabled", {31'b0, irq}, 1);
        wr(3'd1, 32'h6);
        chk("R7 other enables", {31'b0, irq}, 0);

        // R8 raise beats clear in same cycle
        wr(3'd2, 32'h7);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1;
        ev_data = 1'b1; ev_byte = 8'h77;
        @(negedge clk);
        reg_we = 1'b0; ev_data = 1'b0;
        rd(3'd2, v); chk("R8 set wins", v, 32'h1);
        wr(3'd2, 32'h1);
        rd(3'd2, v); chk("R8 w1c", v, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule